// File: doc/BRIEF.md
# SPI ADC Channel Scan Sequencer

This block is a hardware SPI master for an eight-input serial converter. A scan starts with a pulse and an 8-bit channel-enable mask. The block sends one 16-bit command for each enabled input, lowest index first, and then one all-zero command. The converter answers each command one frame late. The block therefore drops the first answer and labels each later answer with the channel commanded in the frame before it.

Each result leaves on a simple stream: a one-cycle valid strobe, a 3-bit channel tag, the 12-bit sample, and a flag on the final sample of the operation. A single-channel read uses the same machinery. It is one command followed by the zero command, and it yields exactly one sample. The serial clock idles high and is made from the system clock by an even divider. Chip select stays low across all frames of one operation.

Top module: `adc_scan_seq`

## Requirements
- R1: The serial clock is high whenever chip select is high. MOSI changes only together with a falling serial-clock edge, and MISO is taken on rising edges.
- R2: Every frame is 16 bits, most significant bit first. A command carries the channel number in bits 13 to 11, and all its other bits are zero.
- R3: A scan sends one command per set bit of `chanMask`, in ascending index order, followed by one all-zero frame. A scan with k enabled channels therefore has k+1 frames.
- R4: The response to the first frame is discarded. The response to frame N is emitted as the sample of the channel commanded in frame N-1, carrying bits 11 to 0 only. Bits 15 to 12 never reach `sampleData`.
- R5: A 12-bit field whose two low bits are zero, as the lower-resolution converter returns, is forwarded unchanged.
- R6: `startSingle` performs exactly two frames: the command for `singleChan`, then the zero frame. It emits one sample, tagged `singleChan`, with `sampleLast` set.
- R7: `csN` goes low once per operation, stays low through every frame of that operation, and returns high after the final frame.
- R8: A start pulse that arrives while `busy` is high is ignored. It does not change the running operation.
- R9: A scan start with an all-zero mask produces no frame and leaves `csN` high. `done` pulses in the cycle after the start.
- R10: `sampleValid` lasts one cycle per sample. `sampleLast` is set only on the last sample of an operation. `done` pulses for one cycle once the operation ends, with `busy` low.
- R11: One serial-clock period lasts 2*SCLK_HALF system-clock cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| startScan | input | 1 | Start a masked scan (takes priority over startSingle) |
| startSingle | input | 1 | Start a single-channel read |
| chanMask | input | 8 | Channel-enable mask; bit i enables channel i |
| singleChan | input | 3 | Channel for a single read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at the end of an operation |
| sclk | output | 1 | Serial clock, idles high |
| csN | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial command out |
| miso | input | 1 | Serial response in |
| sampleValid | output | 1 | One-cycle sample strobe |
| sampleChan | output | 3 | Channel tag of the sample |
| sampleData | output | 12 | Sample value |
| sampleLast | output | 1 | Marks the final sample of an operation |

## Verification
A converter model answers each frame with a value that depends on the channel it received in the previous frame. A mis-tag or a missing one-frame shift therefore shows up directly as a wrong value. The masks tried are:
- one low channel and one high channel, which check the first-frame drop with the shortest scan;
- a full mask, which checks the longest run;
- alternating masks and sparse masks, which check ascending order with gaps.

Separate directed runs cover the single read, the zero-mask scan and a start during a scan. Another run uses values with zero low bits, checking that the reduced-resolution field passes unchanged.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;
  localparam int FRAME_BITS = 16;
  localparam int NUM_CH     = 8;
  localparam int CH_W       = 3;
  localparam int SAMPLE_W   = 12;
  localparam int CMD_LSB    = 11;
  localparam int BIT_W      = $clog2(FRAME_BITS);

  typedef struct packed {
    logic            loadCmd;
    logic            shiftCmd;
    logic            capture;
    logic            frameEnd;
    logic            emit;
    logic            tagLast;
    logic            dummy;
    logic [CH_W-1:0] cmdChan;
    logic [CH_W-1:0] tagChan;
  } seqStrobes_t;
endpackage

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
  import adc_scan_pkg::*;
#(
  parameter int SCLK_HALF = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startScan,
  input  logic              startSingle,
  input  logic [NUM_CH-1:0] chanMask,
  input  logic [CH_W-1:0]   singleChan,
  output logic              busy,
  output logic              done,
  output logic              sclk,
  output logic              csN,
  output seqStrobes_t       strb
);
  localparam int DIV_W = $clog2(SCLK_HALF) + 1;

  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_TAIL} state_t;

  state_t              state;
  logic [DIV_W-1:0]    divCnt;
  logic                sclkReg;
  logic [BIT_W-1:0]    bitIdx;
  logic [NUM_CH-1:0]   pending;
  logic [CH_W-1:0]     cmdChan;
  logic [CH_W-1:0]     prevChan;
  logic                havePrev;
  logic                isDummy;
  logic                doneReg;

  logic                tick;
  logic                fallEdge;
  logic                riseEdge;
  logic                lastBit;
  logic                startReq;
  logic [NUM_CH-1:0]   startMask;

  function automatic logic [CH_W-1:0] firstSet(input logic [NUM_CH-1:0] m);
    logic [CH_W-1:0] r;
    r = '0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (m[i]) r = CH_W'(i);
    end
    return r;
  endfunction

  assign tick      = (divCnt == DIV_W'(SCLK_HALF - 1));
  assign fallEdge  = (state == ST_RUN) && tick && sclkReg;
  assign riseEdge  = (state == ST_RUN) && tick && !sclkReg;
  assign lastBit   = (bitIdx == BIT_W'(FRAME_BITS - 1));
  assign startReq  = startScan || startSingle;
  assign startMask = startScan ? chanMask : (NUM_CH'(1) << singleChan);

  always_comb begin
    strb.loadCmd  = fallEdge && (bitIdx == '0);
    strb.shiftCmd = fallEdge && (bitIdx != '0);
    strb.capture  = riseEdge;
    strb.frameEnd = riseEdge && lastBit;
    strb.emit     = havePrev;
    strb.tagLast  = isDummy;
    strb.dummy    = isDummy;
    strb.cmdChan  = cmdChan;
    strb.tagChan  = prevChan;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      divCnt   <= '0;
      sclkReg  <= 1'b1;
      bitIdx   <= '0;
      pending  <= '0;
      cmdChan  <= '0;
      prevChan <= '0;
      havePrev <= 1'b0;
      isDummy  <= 1'b0;
      doneReg  <= 1'b0;
    end else begin
      doneReg <= 1'b0;
      case (state)
        ST_IDLE: begin
          divCnt  <= '0;
          sclkReg <= 1'b1;
          if (startReq) begin
            if (startMask == '0) begin
              doneReg <= 1'b1;
            end else begin
              state    <= ST_RUN;
              cmdChan  <= firstSet(startMask);
              pending  <= startMask & (startMask - NUM_CH'(1));
              isDummy  <= 1'b0;
              havePrev <= 1'b0;
              bitIdx   <= '0;
            end
          end
        end
        ST_RUN: begin
          if (tick) begin
            divCnt  <= '0;
            sclkReg <= !sclkReg;
            if (!sclkReg) begin
              bitIdx <= lastBit ? '0 : bitIdx + BIT_W'(1);
              if (lastBit) begin
                prevChan <= cmdChan;
                havePrev <= 1'b1;
                if (isDummy) begin
                  state <= ST_TAIL;
                end else if (pending != '0) begin
                  cmdChan <= firstSet(pending);
                  pending <= pending & (pending - NUM_CH'(1));
                end else begin
                  isDummy <= 1'b1;
                  cmdChan <= '0;
                end
              end
            end
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
        default: begin
          if (tick) begin
            state   <= ST_IDLE;
            doneReg <= 1'b1;
            divCnt  <= '0;
          end else begin
            divCnt <= divCnt + DIV_W'(1);
          end
        end
      endcase
    end
  end

  assign busy = (state != ST_IDLE);
  assign done = doneReg;
  assign sclk = sclkReg;
  assign csN  = (state == ST_IDLE);

  AST_START_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(startScan || startSingle)); // R8

  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    done |-> !busy); // R10

  AST_NO_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$past(done)) |-> $stable(csN) || !busy); // R7
endmodule

// File: rtl/adc_scan_dp.sv
module adc_scan_dp
  import adc_scan_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strb,
  input  logic                miso,
  output logic                mosi,
  output logic                sampleValid,
  output logic [CH_W-1:0]     sampleChan,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleLast
);
  logic [FRAME_BITS-1:0] txReg;
  logic [FRAME_BITS-1:0] rxReg;
  logic [FRAME_BITS-1:0] frameWord;
  logic [FRAME_BITS-1:0] cmdWord;

  assign cmdWord   = strb.dummy ? '0 :
                     (FRAME_BITS'(strb.cmdChan) << CMD_LSB);
  assign frameWord = {rxReg[FRAME_BITS-2:0], miso};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      txReg       <= '0;
      rxReg       <= '0;
      sampleValid <= 1'b0;
      sampleChan  <= '0;
      sampleData  <= '0;
      sampleLast  <= 1'b0;
    end else begin
      sampleValid <= 1'b0;
      if (strb.loadCmd) begin
        txReg <= cmdWord;
      end else if (strb.shiftCmd) begin
        txReg <= {txReg[FRAME_BITS-2:0], 1'b0};
      end
      if (strb.capture) begin
        rxReg <= frameWord;
      end
      if (strb.frameEnd && strb.emit) begin
        sampleValid <= 1'b1;
        sampleChan  <= strb.tagChan;
        sampleData  <= frameWord[SAMPLE_W-1:0];
        sampleLast  <= strb.tagLast;
      end
    end
  end

  assign mosi = txReg[FRAME_BITS-1];

  AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |=> !sampleValid); // R10
endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq
  import adc_scan_pkg::*;
#(
  parameter int SCLK_HALF = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                startScan,
  input  logic                startSingle,
  input  logic [NUM_CH-1:0]   chanMask,
  input  logic [CH_W-1:0]     singleChan,
  output logic                busy,
  output logic                done,
  output logic                sclk,
  output logic                csN,
  output logic                mosi,
  input  logic                miso,
  output logic                sampleValid,
  output logic [CH_W-1:0]     sampleChan,
  output logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleLast
);
  seqStrobes_t strb;

  adc_scan_ctrl #(.SCLK_HALF(SCLK_HALF)) uCtrl (
    .clk(clk), .rstN(rstN), .startScan(startScan), .startSingle(startSingle),
    .chanMask(chanMask), .singleChan(singleChan), .busy(busy), .done(done),
    .sclk(sclk), .csN(csN), .strb(strb)
  );

  adc_scan_dp uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .miso(miso), .mosi(mosi),
    .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .sampleLast(sampleLast)
  );

  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> sclk); // R1

  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$stable(mosi)) |-> $fell(sclk)); // R1
endmodule

// File: tb/tb_adc_scan_seq.sv
module tb_adc_scan_seq;
  localparam int HALF = 4;
  localparam logic [7:0] MASKS [8] = '{8'h01, 8'h80, 8'hFF, 8'hA5,
                                      8'h5A, 8'h12, 8'h81, 8'h40};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startScan = 1'b0, startSingle = 1'b0;
  logic [7:0] chanMask = '0;
  logic [2:0] singleChan = '0;
  logic busy, done, sclk, csN, mosi, sampleValid, sampleLast;
  logic miso = 1'b1;
  logic [2:0] sampleChan;
  logic [11:0] sampleData;

  int checks = 0, errors = 0;

  adc_scan_seq #(.SCLK_HALF(HALF)) dut (
    .clk(clk), .rstN(rstN), .startScan(startScan), .startSingle(startSingle),
    .chanMask(chanMask), .singleChan(singleChan), .busy(busy), .done(done),
    .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso),
    .sampleValid(sampleValid), .sampleChan(sampleChan),
    .sampleData(sampleData), .sampleLast(sampleLast)
  );

  always #2 clk = ~clk;

  // converter model
  logic [11:0] valSeed = 12'h0A3;
  bit lowZero = 1'b0;
  logic [15:0] respWord, cmdShift;
  logic [15:0] cmdLog [16];
  int riseCnt = 0, frameCnt = 0, csFalls = 0, periodErr = 0, csEdgeErr = 0;
  time lastRise = 0;

  function automatic logic [11:0] adcVal(input logic [2:0] ch);
    logic [11:0] v;
    v = valSeed + 12'(ch) * 12'h135;
    if (lowZero) v = v & 12'hFFC;
    return v;
  endfunction

  always @(negedge csN) begin
    riseCnt = 0;
    frameCnt = 0;
    respWord = 16'hF5A5;
    csFalls++;
    if (!sclk) csEdgeErr++;
    miso = respWord[15];
  end

  always @(posedge csN) if (!sclk) csEdgeErr++;

  always @(posedge sclk) if (!csN) begin
    if (riseCnt > 0 && ($time - lastRise) != time'(2 * HALF * 4)) periodErr++;
    lastRise = $time;
    cmdShift = {cmdShift[14:0], mosi};
    riseCnt++;
    if (riseCnt % 16 == 0) begin
      if (frameCnt < 16) cmdLog[frameCnt] = cmdShift;
      frameCnt++;
      respWord = {4'hE, adcVal(cmdShift[13:11])};
    end
  end

  always @(negedge sclk) if (!csN) miso = respWord[15 - (riseCnt % 16)];

  // output collector
  logic [2:0]  sChan [16];
  logic [11:0] sData [16];
  logic        sLast [16];
  int n = 0, doneCnt = 0;

  always @(negedge clk) begin
    if (sampleValid && n < 16) begin
      sChan[n] = sampleChan;
      sData[n] = sampleData;
      sLast[n] = sampleLast;
      n++;
    end
    if (done) doneCnt++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clearLog();
    n = 0;
    doneCnt = 0;
    csFalls = 0;
  endtask

  task automatic startOp(input bit single, input logic [7:0] m, input logic [2:0] ch);
    @(negedge clk);
    chanMask = m;
    singleChan = ch;
    startScan = !single;
    startSingle = single;
    @(negedge clk);
    startScan = 1'b0;
    startSingle = 1'b0;
  endtask

  task automatic finishOp(input logic [7:0] m, input string tag);
    logic [2:0] expCh [8];
    int k = 0;
    int w = 0;
    for (int c = 0; c < 8; c++) if (m[c]) begin expCh[k] = 3'(c); k++; end
    while (doneCnt == 0 && w < 20000) begin @(negedge clk); w++; end
    chk(doneCnt == 1, {tag, " R10 done pulse count"}, doneCnt, 1);
    chk(!busy, {tag, " R10 busy low after done"}, busy, 0);
    chk(csN, {tag, " R7 csN released"}, csN, 1);
    chk(csFalls == 1, {tag, " R7 one chip-select assertion"}, csFalls, 1);
    chk(frameCnt == k + 1, {tag, " R3 frame count"}, frameCnt, k + 1);
    chk(n == k, {tag, " R4 sample count"}, n, k);
    for (int i = 0; i < k && i < n; i++) begin
      chk(cmdLog[i] == {2'b00, expCh[i], 11'b0}, {tag, " R2 command word"},
          cmdLog[i], {2'b00, expCh[i], 11'b0});
      chk(sChan[i] == expCh[i], {tag, " R3 channel order/tag"}, sChan[i], expCh[i]);
      chk(sData[i] == adcVal(expCh[i]), {tag, " R4 sample data"}, sData[i], adcVal(expCh[i]));
      chk(sLast[i] == (i == k - 1), {tag, " R10 last flag"}, sLast[i], i == k - 1);
    end
    if (k < 16) chk(cmdLog[k] == 16'h0, {tag, " R3 trailing zero frame"}, cmdLog[k], 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(csN && sclk, "R1 reset idle lines", {csN, sclk}, 2'b11);
    chk(!busy && !done, "R10 reset busy/done", {busy, done}, 0);
    chk(!sampleValid, "R10 reset valid", sampleValid, 0);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    // table-driven scans
    for (int t = 0; t < 8; t++) begin
      valSeed = 12'h0A3 + 12'(t) * 12'h2D1;
      clearLog();
      startOp(1'b0, MASKS[t], 3'd0);
      finishOp(MASKS[t], "scan");
      repeat (5) @(negedge clk);
    end
    chk(periodErr == 0, "R11 sclk period", periodErr, 0);
    chk(csEdgeErr == 0, "R1 sclk high at chip-select edges", csEdgeErr, 0);

    // single-channel read
    clearLog();
    valSeed = 12'h777;
    startOp(1'b1, 8'h00, 3'd5);
    finishOp(8'h20, "R6 single");
    chk(n == 1 && sChan[0] == 3'd5 && sLast[0], "R6 single result", sChan[0], 5);

    // reduced-resolution values pass unchanged
    clearLog();
    lowZero = 1'b1;
    startOp(1'b0, 8'h0C, 3'd0);
    finishOp(8'h0C, "R5 low-zero");
    chk(sData[0] == adcVal(3'd2) && sData[0][1:0] == 2'b00, "R5 passthrough",
        sData[0], adcVal(3'd2));
    lowZero = 1'b0;

    // start while busy is ignored
    clearLog();
    startOp(1'b0, 8'hA5, 3'd0);
    repeat (200) @(negedge clk);
    startOp(1'b0, 8'hFF, 3'd0);
    repeat (100) @(negedge clk);
    startOp(1'b1, 8'h00, 3'd6);
    finishOp(8'hA5, "R8 busy start");
    repeat (50) @(negedge clk);
    chk(n == 4 && !busy, "R8 no restart after scan", n, 4);

    // zero mask
    clearLog();
    @(negedge clk);
    chanMask = 8'h00;
    startScan = 1'b1;
    @(negedge clk);
    startScan = 1'b0;
    chk(done && !busy, "R9 immediate done", {done, busy}, 2'b10);
    @(negedge clk);
    chk(!done, "R9 done one cycle", done, 0);
    repeat (200) @(negedge clk);
    chk(csFalls == 0 && csN, "R9 no chip select", csFalls, 0);
    chk(n == 0, "R9 no samples", n, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule